// File: doc/BRIEF.md
# Parallel-Port Nibble Register Interface

This block sits on the device side of a parallel-port cable. It gives a host access to the register page of a small network controller. The host can only drive eight data lines and read back a few status lines. For that reason, every byte on the data lines is itself a command. The top three bits say what to do, bit 4 picks the upper half, and the low four bits carry either a register offset or a data nibble.

A write runs in four steps. The host first drives an end code. It then drives a write-address byte with the offset, then one or two data-nibble bytes, and finally an end code. The register changes when the closing end code arrives. A read starts with an end code followed by a read-address byte. While the read lasts, the selected nibble of the register appears on status lines [6:3].

The register page holds the following:
- the six-byte station address
- a sixteen-bit transmit count
- read-only transmit and receive status mirrors
- an interrupt status and mask pair
- two command registers
- a mode byte

Control bits from these registers leave the block as ports. The host lines are asynchronous, so they are synchronized and filtered before they are used. The host sees only level changes, so a byte that is repeated unchanged has no effect.

Top module: `pnib_regs`

## Requirements
- R1: A byte on `host_data_i` is acted on only after it has been sampled unchanged on two consecutive clock edges past a two-flop synchronizer. A value present for a single clock cycle is ignored.
- R2: A byte equal to the last accepted byte is ignored. In particular, repeating a write-address byte does not load a data nibble.
- R3: Bits [7:5] are the command field: 3'b111 is the end code, 3'b010 is the write address and 3'b110 is the read address. An address byte is taken only after an end code (or reset), with the offset in bits [3:0] and the half-select H in bit 4.
- R4: In a write with H=0, each data byte with bit 4 = 0 loads the low nibble and each data byte with bit 4 = 1 loads the high nibble (value in bits [3:0]). On the end code the register is updated, and only the halves that were received change.
- R5: In a write with H=1, every data byte loads the high nibble and the low nibble is kept.
- R6: During a read, `host_status_o[6:3]` shows the high nibble (H=1) or low nibble (H=0) of the addressed register. All other status bits are 0, and the whole bus is 0 outside a read. A further read-address byte inside a read retargets it without an end code.
- R7: Register map:
  - offsets 0–5: station address; offset n maps to `station_addr_o[8n+7:8n]`
  - offsets 6/7: low and high byte of `tx_count_o`
  - offset 11: interrupt mask
  - offset 13: command register 2; `accept_mode_o` = bits [5:4]
  - offset 14: `mode_o`
  - offsets 8 and 9: read `tx_stat_i` and `rx_stat_i`
  - offset 15: reads 0
- R8: Offset 10 is interrupt status, with bit 0 transmit OK, bit 1 transmit error and bit 2 receive OK. A pulse on `event_i[k]` sets bit k, and writing 1 to a bit clears it. Bits 7:3 read 0. `irq_o` is set when any status bit is set together with the same bit of the mask.
- R9: Offset 12 is command register 1. The high nibble is stored and readable:
  - bit 7: printer-mux select
  - bit 6: reset
  - bit 5: receive enable
  - bit 4: transmit enable

  In the low nibble, writing 1 to bit 3, 2 or 0 gives a one-cycle pulse on `rexmit_o`, `xmit_o` or `next_pkt_o` respectively. Reading the low nibble gives `irq_o` in bit 1 and 0 elsewhere.
- R10: While the reset bit (offset 12, bit 6) is set, the following are held at 0 and writes to them are lost: transmit count, interrupt status, mask, command register 2 and mode. `tx_en_o` and `rx_en_o` stay low. The station address is kept.
- R11: After `rst_n` is low, all registers, all outputs and the status bus are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| host_data_i | input | 8 | Host data lines, asynchronous |
| host_status_o | output | 8 | Status lines; read nibble on [6:3] |
| tx_stat_i | input | 8 | Transmit status mirrored at offset 8 |
| rx_stat_i | input | 8 | Receive status mirrored at offset 9 |
| event_i | input | 3 | Interrupt event pulses (tx ok, tx err, rx ok) |
| station_addr_o | output | 48 | Station address bytes 0..5 |
| tx_count_o | output | 16 | Transmit byte count |
| mode_o | output | 8 | Mode select byte |
| accept_mode_o | output | 2 | Address accept mode |
| irq_o | output | 1 | Masked interrupt request |
| tx_en_o | output | 1 | Transmit enable |
| rx_en_o | output | 1 | Receive enable |
| mux_sel_o | output | 1 | Printer-mux select |
| soft_rst_o | output | 1 | Reset bit of command register 1 |
| xmit_o | output | 1 | Transmit trigger pulse |
| rexmit_o | output | 1 | Retransmit trigger pulse |
| next_pkt_o | output | 1 | Next-packet pulse |

## Verification
The assertions assume that the host keeps each byte on the data lines for several clock cycles. They also assume that consecutive bytes of a command differ, so the state only moves when a new byte has been accepted and a trigger pulse can never repeat on the next cycle. The stimulus holds every byte for six cycles and builds each command from bytes that differ from their neighbours. The only exceptions are two deliberate cases: a one-cycle glitch and a repeated address byte, both of which the design must reject. Event pulses are driven only between commands, so an interrupt bit is never set in the same cycle as its clearing write.

// File: rtl/pnib_regs.sv
module pnib_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  host_data_i,
  output logic [7:0]  host_status_o,
  input  logic [7:0]  tx_stat_i,
  input  logic [7:0]  rx_stat_i,
  input  logic [2:0]  event_i,
  output logic [47:0] station_addr_o,
  output logic [15:0] tx_count_o,
  output logic [7:0]  mode_o,
  output logic [1:0]  accept_mode_o,
  output logic        irq_o,
  output logic        tx_en_o,
  output logic        rx_en_o,
  output logic        mux_sel_o,
  output logic        soft_rst_o,
  output logic        xmit_o,
  output logic        rexmit_o,
  output logic        next_pkt_o
);

  localparam int SA_BYTES = 6;
  localparam logic [2:0] CMD_END = 3'b111;
  localparam logic [2:0] CMD_WA  = 3'b010;
  localparam logic [2:0] CMD_RA  = 3'b110;
  localparam logic [3:0] OFF_TXC0 = 4'd6;
  localparam logic [3:0] OFF_TXC1 = 4'd7;
  localparam logic [3:0] OFF_TXS  = 4'd8;
  localparam logic [3:0] OFF_RXS  = 4'd9;
  localparam logic [3:0] OFF_ISR  = 4'd10;
  localparam logic [3:0] OFF_IMR  = 4'd11;
  localparam logic [3:0] OFF_C1   = 4'd12;
  localparam logic [3:0] OFF_C2   = 4'd13;
  localparam logic [3:0] OFF_MODE = 4'd14;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_WR = 2'd1, S_RD = 2'd2} st_t;

  logic [7:0] sy1, sy2, sy3, last_q;
  logic       acc;
  logic [2:0] cmd;

  assign acc = (sy2 == sy3) && (sy2 != last_q);
  assign cmd = sy2[7:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1    <= '0;
      sy2    <= '0;
      sy3    <= '0;
      last_q <= '0;
    end else begin
      sy1 <= host_data_i;
      sy2 <= sy1;
      sy3 <= sy2;
      if (acc) last_q <= sy2;
    end
  end

  st_t        st_q;
  logic [3:0] off_q, lo_q, hi_q;
  logic       hsel_q;
  logic [1:0] got_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      off_q  <= '0;
      hsel_q <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
      got_q  <= '0;
    end else if (acc) begin
      case (st_q)
        S_IDLE: begin
          if (cmd == CMD_WA) begin
            st_q   <= S_WR;
            off_q  <= sy2[3:0];
            hsel_q <= sy2[4];
            got_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
          end else if (cmd == CMD_RA) begin
            st_q   <= S_RD;
            off_q  <= sy2[3:0];
            hsel_q <= sy2[4];
          end
        end
        S_WR: begin
          if (cmd == CMD_END) begin
            st_q <= S_IDLE;
          end else if (hsel_q || sy2[4]) begin
            hi_q     <= sy2[3:0];
            got_q[1] <= 1'b1;
          end else begin
            lo_q     <= sy2[3:0];
            got_q[0] <= 1'b1;
          end
        end
        S_RD: begin
          if (cmd == CMD_END) begin
            st_q <= S_IDLE;
          end else if (cmd == CMD_RA) begin
            off_q  <= sy2[3:0];
            hsel_q <= sy2[4];
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  logic [7:0] sa_q [SA_BYTES];
  logic [7:0] txc_q [2];
  logic [2:0] isr_q;
  logic [7:0] imr_q, cmr2_q, mode_q;
  logic [3:0] c1h_q;
  logic [2:0] pulse_q;
  logic [7:0] rv, wv;
  logic       commit, isr_clr;
  logic [2:0] isr_d;

  assign commit  = acc && (st_q == S_WR) && (cmd == CMD_END) && (got_q != 2'b00);
  assign isr_clr = commit && (off_q == OFF_ISR) && got_q[0];
  assign isr_d   = (isr_clr ? (isr_q & ~lo_q[2:0]) : isr_q) | event_i;
  assign irq_o   = |(isr_q & imr_q[2:0]);

  always_comb begin
    rv = '0;
    if (off_q < 4'(SA_BYTES)) begin
      rv = sa_q[off_q[2:0]];
    end else begin
      case (off_q)
        OFF_TXC0: rv = txc_q[0];
        OFF_TXC1: rv = txc_q[1];
        OFF_TXS:  rv = tx_stat_i;
        OFF_RXS:  rv = rx_stat_i;
        OFF_ISR:  rv = {5'b0, isr_q};
        OFF_IMR:  rv = imr_q;
        OFF_C1:   rv = {c1h_q, 2'b00, irq_o, 1'b0};
        OFF_C2:   rv = cmr2_q;
        OFF_MODE: rv = mode_q;
        default:  rv = '0;
      endcase
    end
  end

  assign wv = {got_q[1] ? hi_q : rv[7:4], got_q[0] ? lo_q : rv[3:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SA_BYTES; i++) sa_q[i] <= '0;
      txc_q[0] <= '0;
      txc_q[1] <= '0;
      isr_q    <= '0;
      imr_q    <= '0;
      cmr2_q   <= '0;
      mode_q   <= '0;
      c1h_q    <= '0;
      pulse_q  <= '0;
    end else begin
      pulse_q <= '0;
      isr_q   <= isr_d;
      if (commit) begin
        if (off_q < 4'(SA_BYTES)) begin
          sa_q[off_q[2:0]] <= wv;
        end else begin
          case (off_q)
            OFF_TXC0: txc_q[0] <= wv;
            OFF_TXC1: txc_q[1] <= wv;
            OFF_IMR:  imr_q    <= wv;
            OFF_C2:   cmr2_q   <= wv;
            OFF_MODE: mode_q   <= wv;
            OFF_C1: begin
              if (got_q[1]) c1h_q <= hi_q;
              if (got_q[0]) pulse_q <= {lo_q[3], lo_q[2], lo_q[0]};
            end
            default: ;
          endcase
        end
      end
      if (c1h_q[2]) begin
        txc_q[0] <= '0;
        txc_q[1] <= '0;
        isr_q    <= '0;
        imr_q    <= '0;
        cmr2_q   <= '0;
        mode_q   <= '0;
      end
    end
  end

  for (genvar g = 0; g < SA_BYTES; g++) begin : g_sa
    assign station_addr_o[8*g +: 8] = sa_q[g];
  end

  assign host_status_o = (st_q == S_RD) ? {1'b0, (hsel_q ? rv[7:4] : rv[3:0]), 3'b000} : 8'h00;
  assign tx_count_o    = {txc_q[1], txc_q[0]};
  assign mode_o        = mode_q;
  assign accept_mode_o = cmr2_q[5:4];
  assign mux_sel_o     = c1h_q[3];
  assign soft_rst_o    = c1h_q[2];
  assign rx_en_o       = c1h_q[1] & ~c1h_q[2];
  assign tx_en_o       = c1h_q[0] & ~c1h_q[2];
  assign rexmit_o      = pulse_q[2];
  assign xmit_o        = pulse_q[1];
  assign next_pkt_o    = pulse_q[0];

endmodule

// File: rtl/pnib_regs_chk.sv
module pnib_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  st,
  input logic [7:0]  last,
  input logic [47:0] sa,
  input logic [15:0] txc,
  input logic [7:0]  mode,
  input logic        srst,
  input logic        xm,
  input logic [7:0]  stat
);

  // R1
  state_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st)) |-> (last != $past(last)));

  // R3
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st != 2'd3);

  // R7
  sa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sa != $past(sa)) |-> ($past(st) == 2'd1));

  // R10
  soft_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && $past(srst)) |-> (txc == 16'h0 && mode == 8'h0));

  // R9
  xmit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xm |=> !xm);

  // R6
  status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[7] == 1'b0) && (stat[2:0] == 3'b000) && ((st != 2'd2) -> (stat == 8'h00)));

endmodule

bind pnib_regs pnib_regs_chk u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .st   (st_q),
  .last (last_q),
  .sa   (station_addr_o),
  .txc  (tx_count_o),
  .mode (mode_o),
  .srst (soft_rst_o),
  .xm   (xmit_o),
  .stat (host_status_o)
);

// File: tb/pnib_regs_test.sv
module pnib_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_data_i = 8'h00;
  logic [7:0]  host_status_o;
  logic [7:0]  tx_stat_i = 8'hA5;
  logic [7:0]  rx_stat_i = 8'h3C;
  logic [2:0]  event_i = 3'b000;
  logic [47:0] station_addr_o;
  logic [15:0] tx_count_o;
  logic [7:0]  mode_o;
  logic [1:0]  accept_mode_o;
  logic irq_o, tx_en_o, rx_en_o, mux_sel_o, soft_rst_o, xmit_o, rexmit_o, next_pkt_o;

  int n_run = 0, n_fail = 0, n_xmit = 0, n_rexmit = 0, n_next = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pnib_regs uut (.*);

  always @(posedge clk) begin
    if (xmit_o) n_xmit++;
    if (rexmit_o) n_rexmit++;
    if (next_pkt_o) n_next++;
  end

  task automatic chk(input string r, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  task automatic put(input int b);
    @(negedge clk) host_data_i = 8'(b);
    repeat (5) @(negedge clk);
  endtask

  task automatic wr(input int off, input int v);
    put(8'hE0 | off);
    put(8'h40 | off);
    put(v & 15);
    put(8'h10 | ((v >> 4) & 15));
    put(8'hE0);
  endtask

  task automatic rd(input int off, input int h, output int nib);
    put(8'hE0 | off);
    put(8'hC0 | (h << 4) | off);
    nib = (host_status_o >> 3) & 15;
    put(8'hE0);
  endtask

  task automatic rd_byte(input int off, output int v);
    int lo, hi;
    rd(off, 0, lo);
    rd(off, 1, hi);
    v = (hi << 4) | lo;
  endtask

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 status", host_status_o, 0);
    chk("R11 station", int'(station_addr_o[31:0]), 0);
    chk("R11 outputs", {tx_en_o, rx_en_o, irq_o, soft_rst_o, tx_count_o}, 0);

    // R4 R6 R7 sweep of every byte value over the station address
    for (int i = 0; i < 256; i++) begin
      int off, lo, hi;
      off = i % 6;
      wr(off, i);
      rd(off, 0, lo);
      rd(off, 1, hi);
      chk("R4 lo nibble", lo, i & 15);
      chk("R6 hi nibble", hi, i >> 4);
      chk("R7 station port", int'(station_addr_o[8*off +: 8]), i);
    end

    // R7 other read/write registers
    for (int i = 0; i < 4; i++) begin
      int pat;
      pat = 8'h1F + i * 8'h47;
      wr(6, pat); wr(7, pat ^ 8'hFF);
      chk("R7 tx count", tx_count_o, ((pat ^ 8'hFF) << 8) | pat);
      wr(13, pat);
      chk("R7 accept mode", accept_mode_o, (pat >> 4) & 3);
      rd_byte(13, v); chk("R7 cmd2 read", v, pat);
      wr(14, pat);
      chk("R7 mode port", mode_o, pat);
      wr(11, pat);
      rd_byte(11, v); chk("R7 mask read", v, pat);
    end
    rd_byte(8, v); chk("R7 tx stat", v, 8'hA5);
    rd_byte(9, v); chk("R7 rx stat", v, 8'h3C);
    rd_byte(15, v); chk("R7 offset 15", v, 0);

    // R5 high-nibble write, R4 partial byte write
    wr(14, 8'h5A);
    put(8'hEE); put(8'h5E); put(8'h03); put(8'hE0);
    chk("R5 high nibble only", mode_o, 8'h3A);
    put(8'hEE); put(8'h4E); put(8'h0C); put(8'hE0);
    chk("R4 low half only", mode_o, 8'h3C);

    // R1 one-cycle glitch ignored
    put(8'hEE); put(8'h4E); put(8'h01);
    @(negedge clk) host_data_i = 8'h1F;
    @(negedge clk) host_data_i = 8'h01;
    repeat (5) @(negedge clk);
    put(8'hE0);
    chk("R1 glitch", mode_o, 8'h31);

    // R2 repeated address byte not taken as data
    put(8'hEE); put(8'h4E); put(8'h4E); put(8'h12); put(8'hE0);
    chk("R2 duplicate", mode_o, 8'h21);

    // R3 address byte without a preceding end code is data, not address
    put(8'hED); put(8'h4D); put(8'h4E); put(8'h17); put(8'hE0);
    rd_byte(13, v); chk("R3 address needs end code", v, 8'h7E);
    chk("R3 mode untouched", mode_o, 8'h21);

    // R6 read retarget and quiet status
    wr(1, 8'h96); wr(2, 8'h69);
    put(8'hE1); put(8'hC1);
    chk("R6 first target", (host_status_o >> 3) & 15, 6);
    put(8'hD2);
    chk("R6 retarget", (host_status_o >> 3) & 15, 6);
    put(8'hC2);
    chk("R6 retarget lo", (host_status_o >> 3) & 15, 9);
    chk("R6 unused bits", host_status_o & 8'h87, 0);
    put(8'hE0);
    chk("R6 idle status", host_status_o, 0);

    // R8 interrupt status and mask
    wr(11, 8'h04);
    @(negedge clk) event_i = 3'b011;
    @(negedge clk) event_i = 3'b000;
    @(negedge clk);
    rd_byte(10, v); chk("R8 isr set", v, 3);
    chk("R8 irq masked", irq_o, 0);
    @(negedge clk) event_i = 3'b100;
    @(negedge clk) event_i = 3'b000;
    @(negedge clk);
    chk("R8 irq", irq_o, 1);
    rd_byte(12, v); chk("R9 irq in cmd1", v & 15, 2);
    wr(10, 8'hF5);
    rd_byte(10, v); chk("R8 write one clears", v, 2);
    chk("R8 irq cleared", irq_o, 0);

    // R9 command register 1
    n = n_xmit;
    wr(12, 8'hB4);
    chk("R9 xmit pulse", n_xmit - n, 1);
    chk("R9 enables", {mux_sel_o, soft_rst_o, rx_en_o, tx_en_o}, 4'b1011);
    rd_byte(12, v); chk("R9 cmd1 read", v, 8'hB0);
    wr(12, 8'h39);
    chk("R9 rexmit pulse", n_rexmit, 1);
    chk("R9 next pulse", n_next, 1);
    chk("R9 xmit no extra", n_xmit - n, 1);

    // R10 reset bit
    wr(6, 8'h77); wr(14, 8'h42); wr(3, 8'hC3);
    wr(12, 8'h70);
    repeat (2) @(negedge clk);
    chk("R10 enables low", {tx_en_o, rx_en_o, soft_rst_o}, 3'b001);
    chk("R10 count cleared", tx_count_o, 0);
    chk("R10 mode cleared", mode_o, 0);
    chk("R10 station kept", int'(station_addr_o[31:24]), 8'hC3);
    wr(6, 8'h55);
    chk("R10 write lost", tx_count_o, 0);
    wr(12, 8'h30);
    chk("R10 enables back", {tx_en_o, rx_en_o, soft_rst_o}, 3'b110);
    wr(6, 8'h55);
    chk("R10 write after release", tx_count_o, 8'h55);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule